// File: doc/BRIEF.md
# Disk Command Decoder and Gate

This block sits behind the command register of a disk controller's host port. When the host writes an 8-bit command code, the block classifies it into one of fifteen operations. Codes with don't-care low bits, and codes that carry mode bits inside them, both map onto that set. The block also pulls out the long-mode and retry-disable flags. It then checks the drive condition. If the drive can take the command, the block issues a one-cycle start pulse and holds busy until the executing logic reports completion. If not, it aborts at once and writes the aborted-command error code.

The command write is a valid/ready stream. `cmd_ready` is high exactly when the block is not busy. A code is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While busy, the host must hold or drop its request, and nothing is consumed. The drive-condition inputs, the completion pulse and the result outputs are plain levels and pulses.

Top module: `disk_cmd_check`

## Requirements
- R1: Codes 0x10 to 0x1F decode as recalibrate (op 1), and codes 0x70 to 0x7F decode as seek (op 2). The low nibble has no effect on either.
- R2: Code 0b0010_00LR decodes as read (op 3) and 0b0011_00LR as write (op 4). `long_mode` takes bit 1 (L) and `no_retry` takes bit 0 (R).
- R3: Code 0b0100_000R decodes as verify (op 6), with `no_retry` taken from bit 0. Code 0x50 decodes as format (op 5).
- R4: Each fixed code decodes to its own op: 0x90 diagnostic = 7, 0x91 set parameters = 8, 0xC4 = 9, 0xC5 = 10, 0xC6 = 11, 0xE4 = 12, 0xE8 = 13, 0xEC = 14, 0xEF = 15. Every other code is op 0 (invalid), with both flags low.
- R5: A command accepted while `drv_ready` is 0 produces `abort_pulse` and no `start_pulse`.
- R6: A command accepted while `wr_fault` is 1 produces `abort_pulse` and no `start_pulse`.
- R7: An invalid code, including the reserved 0xE0, aborts and leaves `err_reg` = 0x04 (bit 2, aborted command).
- R8: In the cycle `abort_pulse` is high, `err_status` and `irq_set` are also high and `busy` is low.
- R9: An accepted command with a valid code, ready drive and no fault gives `start_pulse` one cycle after acceptance. It sets `busy`, clears `err_reg` and `err_status`, and latches op, flags and count.
- R10: `xfer_count` is the sector count latched at acceptance, with 0 reported as 256.
- R11: `cmd_ready` is the inverse of `busy`. An `exec_done` while busy clears `busy` and raises `irq_set`. It loads `err_reg` from `exec_err`, with bits 5 and 3 forced to 0 (bit 7 bad block, 6 uncorrectable, 4 ID not found, 2 aborted, 1 track 0, 0 address mark). `err_status` is set when the result is nonzero.
- R12: `exec_done` while idle changes nothing. After reset, `busy`, the pulses, `err_status`, `err_reg` and `op_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command write present |
| cmd_ready | output | 1 | Block can take a command (not busy) |
| cmd_code | input | 8 | Command code |
| sec_count | input | 8 | Sector count register value |
| drv_ready | input | 1 | Target drive ready |
| wr_fault | input | 1 | Write fault present |
| exec_done | input | 1 | Executing logic finished the command |
| exec_err | input | 8 | Error bits reported at completion |
| op_code | output | 4 | Latched operation |
| long_mode | output | 1 | Latched long-mode flag |
| no_retry | output | 1 | Latched retry-disable flag |
| xfer_count | output | 9 | Latched sector count, 1 to 256 |
| start_pulse | output | 1 | One-cycle start of execution |
| abort_pulse | output | 1 | One-cycle command refusal |
| irq_set | output | 1 | One-cycle request to raise host interrupt |
| busy | output | 1 | Command executing |
| err_status | output | 1 | Status error bit |
| err_reg | output | 8 | Error register |

## Verification
The assertions run on every cycle. They check that a refusal from a not-ready or faulted drive always turns into an abort, and that an abort always comes with the 0x04 error code, the status error bit and an interrupt request, with busy low. They also check that start and abort never appear together, that the reserved error bits stay zero, and that busy always blocks the handshake. Only the bench's scenarios can show the mapping of each code to its op and flags, the don't-care nibbles, the count of 256 for zero, the masking of completion errors, and that a stray completion pulse while idle is ignored.

// File: rtl/cmdv_pkg.sv
package cmdv_pkg;
  typedef enum logic [3:0] {
    OP_INVALID = 4'd0,  OP_RECAL   = 4'd1,  OP_SEEK    = 4'd2,  OP_READ    = 4'd3,
    OP_WRITE   = 4'd4,  OP_FORMAT  = 4'd5,  OP_VERIFY  = 4'd6,  OP_DIAG    = 4'd7,
    OP_SETPARM = 4'd8,  OP_RDMULT  = 4'd9,  OP_WRMULT  = 4'd10, OP_SETMULT = 4'd11,
    OP_RDBUF   = 4'd12, OP_WRBUF   = 4'd13, OP_IDENT   = 4'd14, OP_SETBUF  = 4'd15
  } op_e;

  localparam int EB_BADBLK = 7;
  localparam int EB_UNCORR = 6;
  localparam int EB_IDNF   = 4;
  localparam int EB_ABORT  = 2;
  localparam int EB_TRK0   = 1;
  localparam int EB_NOAM   = 0;

  localparam logic [7:0] ERR_KEEP = (8'd1 << EB_BADBLK) | (8'd1 << EB_UNCORR) |
                                    (8'd1 << EB_IDNF)   | (8'd1 << EB_ABORT)  |
                                    (8'd1 << EB_TRK0)   | (8'd1 << EB_NOAM);
  localparam logic [7:0] ERR_ABORTED = 8'd1 << EB_ABORT;
endpackage

// File: rtl/cmdv_decode.sv
module cmdv_decode
  import cmdv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  output op_e               op,
  output logic              long_f,
  output logic              noretry_f
);
  localparam int HI = CODE_W - 1;

  always_comb begin
    op        = OP_INVALID;
    long_f    = 1'b0;
    noretry_f = 1'b0;
    unique casez (code[HI -: 8])
      8'b0001_????: op = OP_RECAL;
      8'b0111_????: op = OP_SEEK;
      8'b0010_00??: begin op = OP_READ;  long_f = code[1]; noretry_f = code[0]; end
      8'b0011_00??: begin op = OP_WRITE; long_f = code[1]; noretry_f = code[0]; end
      8'b0100_000?: begin op = OP_VERIFY; noretry_f = code[0]; end
      8'h50: op = OP_FORMAT;
      8'h90: op = OP_DIAG;
      8'h91: op = OP_SETPARM;
      8'hC4: op = OP_RDMULT;
      8'hC5: op = OP_WRMULT;
      8'hC6: op = OP_SETMULT;
      8'hE4: op = OP_RDBUF;
      8'hE8: op = OP_WRBUF;
      8'hEC: op = OP_IDENT;
      8'hEF: op = OP_SETBUF;
      default: op = OP_INVALID;
    endcase
  end
endmodule

// File: rtl/cmdv_gate.sv
module cmdv_gate
  import cmdv_pkg::*;
#(
  parameter int SC_W = 8,
  localparam int XC_W = SC_W + 1
) (
  input  op_e             op,
  input  logic            drv_ready,
  input  logic            wr_fault,
  input  logic [SC_W-1:0] sc_raw,
  output logic            go,
  output logic [XC_W-1:0] sc_eff
);
  always_comb begin
    go     = drv_ready && !wr_fault && (op != OP_INVALID);
    sc_eff = (sc_raw == '0) ? (XC_W'(1) << SC_W) : {1'b0, sc_raw};
  end
endmodule

// File: rtl/cmdv_state.sv
module cmdv_state
  import cmdv_pkg::*;
#(
  parameter int SC_W = 8,
  localparam int XC_W = SC_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            go,
  input  op_e             op_in,
  input  logic            long_in,
  input  logic            nr_in,
  input  logic [XC_W-1:0] cnt_in,
  input  logic            done,
  input  logic [7:0]      done_err,
  output logic [3:0]      op_q,
  output logic            long_q,
  output logic            nr_q,
  output logic [XC_W-1:0] cnt_q,
  output logic            start_q,
  output logic            abort_q,
  output logic            irq_q,
  output logic            busy_q,
  output logic            stat_err_q,
  output logic [7:0]      err_q
);
  logic [7:0] kept_err;
  assign kept_err = done_err & ERR_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= '0;
      long_q     <= 1'b0;
      nr_q       <= 1'b0;
      cnt_q      <= '0;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
      irq_q      <= 1'b0;
      busy_q     <= 1'b0;
      stat_err_q <= 1'b0;
      err_q      <= '0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
      if (take) begin
        op_q    <= op_in;
        long_q  <= long_in;
        nr_q    <= nr_in;
        cnt_q   <= cnt_in;
        start_q <= go;
        abort_q <= !go;
        irq_q   <= !go;
        busy_q  <= go;
        stat_err_q <= !go;
        err_q   <= go ? 8'h00 : ERR_ABORTED;
      end else if (done && busy_q) begin
        busy_q     <= 1'b0;
        irq_q      <= 1'b1;
        err_q      <= kept_err;
        stat_err_q <= |kept_err;
      end
    end
  end

  // R8: abort comes with error code, status error, interrupt, and no busy
  a_r8_abort_side: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (err_q == ERR_ABORTED) && stat_err_q && irq_q && !busy_q);
  // R9: start and abort are exclusive
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && abort_q));
  // R11: unused error bits stay clear
  a_r11_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[5] == 1'b0) && (err_q[3] == 1'b0));
  // R10: latched count is never zero after a start
  a_r10_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (cnt_q != '0));
endmodule

// File: rtl/disk_cmd_check.sv
module disk_cmd_check
  import cmdv_pkg::*;
#(
  parameter int SC_W = 8,
  localparam int XC_W = SC_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [7:0]      cmd_code,
  input  logic [SC_W-1:0] sec_count,
  input  logic            drv_ready,
  input  logic            wr_fault,
  input  logic            exec_done,
  input  logic [7:0]      exec_err,
  output logic [3:0]      op_code,
  output logic            long_mode,
  output logic            no_retry,
  output logic [XC_W-1:0] xfer_count,
  output logic            start_pulse,
  output logic            abort_pulse,
  output logic            irq_set,
  output logic            busy,
  output logic            err_status,
  output logic [7:0]      err_reg
);
  op_e             dec_op;
  logic            dec_long, dec_nr, ok;
  logic [XC_W-1:0] eff_cnt;
  logic            take;

  assign cmd_ready = !busy;
  assign take      = cmd_valid && cmd_ready;

  cmdv_decode #(.CODE_W(8)) u_dec (
    .code(cmd_code), .op(dec_op), .long_f(dec_long), .noretry_f(dec_nr)
  );

  cmdv_gate #(.SC_W(SC_W)) u_gate (
    .op(dec_op), .drv_ready(drv_ready), .wr_fault(wr_fault),
    .sc_raw(sec_count), .go(ok), .sc_eff(eff_cnt)
  );

  cmdv_state #(.SC_W(SC_W)) u_state (
    .clk(clk), .rst_n(rst_n), .take(take), .go(ok),
    .op_in(dec_op), .long_in(dec_long), .nr_in(dec_nr), .cnt_in(eff_cnt),
    .done(exec_done), .done_err(exec_err),
    .op_q(op_code), .long_q(long_mode), .nr_q(no_retry), .cnt_q(xfer_count),
    .start_q(start_pulse), .abort_q(abort_pulse), .irq_q(irq_set),
    .busy_q(busy), .stat_err_q(err_status), .err_q(err_reg)
  );

  // R5: not-ready drive turns an accepted command into an abort
  a_r5_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !drv_ready) |=> (abort_pulse && !start_pulse));
  // R6: write fault refuses new commands
  a_r6_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && wr_fault) |=> (abort_pulse && !start_pulse));
  // R11: busy blocks the handshake
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

// File: tb/test_disk_cmd_check.sv
module test_disk_cmd_check;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, drv_ready = 1'b1, wr_fault = 1'b0, exec_done = 1'b0;
  logic [7:0] cmd_code = '0, sec_count = 8'd1, exec_err = '0;
  logic cmd_ready, long_mode, no_retry, start_pulse, abort_pulse, irq_set, busy, err_status;
  logic [3:0] op_code;
  logic [8:0] xfer_count;
  logic [7:0] err_reg;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  disk_cmd_check i_disk_cmd_check (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .sec_count(sec_count), .drv_ready(drv_ready),
    .wr_fault(wr_fault), .exec_done(exec_done), .exec_err(exec_err),
    .op_code(op_code), .long_mode(long_mode), .no_retry(no_retry),
    .xfer_count(xfer_count), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .irq_set(irq_set), .busy(busy), .err_status(err_status), .err_reg(err_reg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {code, ready, fault, op, L, R, start}
  localparam int NV = 27;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {8'h10,1'b1,1'b0,4'd1,1'b0,1'b0,1'b1},
    {8'h1F,1'b1,1'b0,4'd1,1'b0,1'b0,1'b1},
    {8'h7A,1'b1,1'b0,4'd2,1'b0,1'b0,1'b1},
    {8'h20,1'b1,1'b0,4'd3,1'b0,1'b0,1'b1},
    {8'h23,1'b1,1'b0,4'd3,1'b1,1'b1,1'b1},
    {8'h31,1'b1,1'b0,4'd4,1'b0,1'b1,1'b1},
    {8'h32,1'b1,1'b0,4'd4,1'b1,1'b0,1'b1},
    {8'h40,1'b1,1'b0,4'd6,1'b0,1'b0,1'b1},
    {8'h41,1'b1,1'b0,4'd6,1'b0,1'b1,1'b1},
    {8'h50,1'b1,1'b0,4'd5,1'b0,1'b0,1'b1},
    {8'h90,1'b1,1'b0,4'd7,1'b0,1'b0,1'b1},
    {8'h91,1'b1,1'b0,4'd8,1'b0,1'b0,1'b1},
    {8'hC4,1'b1,1'b0,4'd9,1'b0,1'b0,1'b1},
    {8'hC5,1'b1,1'b0,4'd10,1'b0,1'b0,1'b1},
    {8'hC6,1'b1,1'b0,4'd11,1'b0,1'b0,1'b1},
    {8'hE4,1'b1,1'b0,4'd12,1'b0,1'b0,1'b1},
    {8'hE8,1'b1,1'b0,4'd13,1'b0,1'b0,1'b1},
    {8'hEC,1'b1,1'b0,4'd14,1'b0,1'b0,1'b1},
    {8'hEF,1'b1,1'b0,4'd15,1'b0,1'b0,1'b1},
    {8'hE0,1'b1,1'b0,4'd0,1'b0,1'b0,1'b0},
    {8'h00,1'b1,1'b0,4'd0,1'b0,1'b0,1'b0},
    {8'h42,1'b1,1'b0,4'd0,1'b0,1'b0,1'b0},
    {8'h24,1'b1,1'b0,4'd0,1'b0,1'b0,1'b0},
    {8'h51,1'b1,1'b0,4'd0,1'b0,1'b0,1'b0},
    {8'h20,1'b0,1'b0,4'd3,1'b0,1'b0,1'b0},
    {8'h33,1'b1,1'b1,4'd4,1'b1,1'b1,1'b0},
    {8'h1C,1'b0,1'b1,4'd1,1'b0,1'b0,1'b0}
  };

  task automatic issue(logic [7:0] c, logic r, logic f, logic [7:0] sc);
    @(negedge clk);
    cmd_code = c; drv_ready = r; wr_fault = f; sec_count = sc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd(logic [7:0] e);
    exec_done = 1'b1; exec_err = e;
    @(negedge clk);
    exec_done = 1'b0; exec_err = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 busy", busy, 0);
    check("R12 ready", cmd_ready, 1);
    check("R12 pulses", {start_pulse, abort_pulse, irq_set}, 0);
    check("R12 err", {err_status, err_reg}, 0);
    check("R12 op", op_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      issue(v[16:9], v[8], v[7], 8'd4);
      // R1 R2 R3 R4: decode; R5 R6 R7 R9: outcome
      check("R1-R4 op", op_code, v[6:3]);
      check("R2 long", long_mode, v[2]);
      check("R2 R3 noretry", no_retry, v[1]);
      check("R9 start", start_pulse, v[0]);
      check("R5 R6 R7 abort", abort_pulse, !v[0]);
      if (v[0]) begin
        check("R9 busy", busy, 1);
        check("R9 err clear", {err_status, err_reg}, 0);
        finish_cmd(8'h00);
      end else begin
        check("R7 err", err_reg, 8'h04);
        check("R8 side", {err_status, irq_set, busy}, 3'b110);
      end
    end

    // R10: zero count means 256
    issue(8'h20, 1'b1, 1'b0, 8'd0);
    check("R10 count 256", xfer_count, 9'd256);
    finish_cmd(8'h00);
    issue(8'h30, 1'b1, 1'b0, 8'd255);
    check("R10 count 255", xfer_count, 9'd255);

    // R11: busy blocks; a further write is not taken
    check("R11 ready low", cmd_ready, 0);
    @(negedge clk);
    cmd_code = 8'hE0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 held off", {abort_pulse, op_code}, {1'b0, 4'd4});
    // R11: completion loads masked error
    finish_cmd(8'hFF);
    check("R11 err masked", err_reg, 8'hD7);
    check("R11 done side", {busy, irq_set, err_status, cmd_ready}, 4'b0111);
    @(negedge clk);
    check("R11 irq single", irq_set, 0);

    // R12: stray completion while idle ignored
    finish_cmd(8'h10);
    check("R12 idle done", {err_reg, irq_set, busy}, {8'hD7, 2'b00});

    // R11: clean completion clears error status
    issue(8'h70, 1'b1, 1'b0, 8'd1);
    finish_cmd(8'h00);
    check("R11 clean", {err_status, err_reg}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule